// File: doc/BRIEF.md
# Supply Startup Sequencer

This block manages how a switching controller brings up its own supply rail. It takes digital flags from comparators on the supply rail and on the high-voltage input. From them it chooses which startup current source charges the rail, and decides when the converter may begin switching. It also handles the case where the rail sags and has to be recharged.

While the rail is nearly empty, a weak current source charges it. Above a first threshold a strong source takes over. At the turn-on level both sources stop, and a bias-settling delay runs before switching is allowed. If a fault is present, the block withholds switching. The rail then decays and is recharged in a hiccup loop until the fault goes away.

A sustained supply overvoltage puts the block into a latched quiet state. Only a deep discharge of the rail releases it. All comparator flags pass through two-flop synchronisers. Every delay is counted in ticks of a parameterised prescaler.

Top module: `supply_seq`

## Requirements
- R1: While rstN is low at a clock edge, all four outputs (lowSrcEn, highSrcEn, switchGo, ovpLatched) are 0 after that edge.
- R2: In the charging phase, lowSrcEn is 1 only when hvOk is 1 and railAboveInh is 0. With hvOk at 0, neither source is enabled. lowSrcEn and highSrcEn are never 1 together.
- R3: In the charging phase with hvOk at 1, railAboveInh at 1 selects highSrcEn instead of lowSrcEn. A return of railAboveInh to 0 reselects lowSrcEn.
- R4: Once railAboveOn is seen, both sources are off, and they stay off whenever switchGo is 1.
- R5: switchGo rises no earlier than (START_TICKS-1)*PRESCALE cycles after railAboveOn is seen. It rises within START_TICKS*PRESCALE plus a few cycles of synchroniser and state latency.
- R6: If faultIn is 1 when the startup delay ends, switchGo stays 0. The rail is recharged through the off-timeout path as it sags. Switching begins only after faultIn returns to 0 and the startup delay runs again.
- R7: When railBelowOff rises during switching, switchGo holds for OFF_TICKS ticks, then falls, and charging resumes. If railBelowOff clears before the timeout, switching continues.
- R8: railOvp must stay 1 for OVP_TICKS ticks to latch. Once latched, ovpLatched is 1 and all other outputs are 0. A shorter railOvp pulse has no effect.
- R9: ovpLatched stays 1 after railOvp falls and while the rail discharges. Only railBelowRst at 1 clears it, returning the block to charging.
- R10: A fault arriving while switching drops switchGo within a few cycles, without enabling either source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| hvOk | input | 1 | High-voltage input above its minimum level |
| railAboveInh | input | 1 | Rail above the inhibit threshold |
| railAboveOn | input | 1 | Rail above the turn-on threshold |
| railBelowOff | input | 1 | Rail below the minimum operating threshold |
| railBelowRst | input | 1 | Rail below the deep-discharge reset threshold |
| railOvp | input | 1 | Rail above the overvoltage threshold |
| faultIn | input | 1 | Any external fault present |
| lowSrcEn | output | 1 | Enable for the weak startup current |
| highSrcEn | output | 1 | Enable for the strong startup current |
| switchGo | output | 1 | Converter switching permitted |
| ovpLatched | output | 1 | Latched supply overvoltage, low-power state |

## Verification
The bench brackets the startup delay and the off timeout with a lower and an upper sample. An off-by-one tick counter, or a missing delay, therefore shows up as an early or late switchGo. Separate cases cover a brief undervoltage dip, which a design without a cancel path would treat as a full shutdown, and a short overvoltage glitch, which a design without qualification would latch on. The bench then holds the latch while the rail falls only through the off threshold. A design that clears it on the wrong threshold would resume charging there. The hiccup sequence with a lingering fault exposes a design that starts switching as soon as the delay ends without looking at the fault.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    ST_CHARGE    = 3'd0,
    ST_STARTWAIT = 3'd1,
    ST_RUN       = 3'd2,
    ST_HOLD      = 3'd3,
    ST_OFFWAIT   = 3'd4,
    ST_OVPLATCH  = 3'd5
  } seqState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic tmrClr;   // restart the phase timer
    logic selOff;   // 1: compare with off timeout, 0: startup delay
  } seqStrobe_t;
endpackage

// File: rtl/ssq_sync.sv
module ssq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= din[i];
        stage2 <= stage1;
      end
    end
    assign dout[i] = stage2;
  end
endmodule

// File: rtl/ssq_timebase.sv
module ssq_timebase
  import ssq_pkg::*;
#(
  parameter int PRESCALE    = 100,
  parameter int START_TICKS = 34,
  parameter int OFF_TICKS   = 42,
  parameter int OVP_TICKS   = 63
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       ovpS,
  output logic       tmrDone,
  output logic       ovpQual
);
  localparam int TMAX = (START_TICKS > OFF_TICKS) ? START_TICKS : OFF_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int OW   = $clog2(OVP_TICKS + 1);

  logic tick;

  if (PRESCALE <= 1) begin : g_noPre
    assign tick = 1'b1;
  end else begin : g_pre
    localparam int PW = $clog2(PRESCALE);
    logic [PW-1:0] preCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                             preCnt <= '0;
      else if (preCnt == PW'(PRESCALE - 1))  preCnt <= '0;
      else                                   preCnt <= preCnt + 1'b1;
    end
    assign tick = (preCnt == PW'(PRESCALE - 1));
  end

  logic [TW-1:0] tmrCnt;
  logic [TW-1:0] tmrLimit;
  assign tmrLimit = strobe.selOff ? TW'(OFF_TICKS) : TW'(START_TICKS);
  assign tmrDone  = (tmrCnt >= tmrLimit);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.tmrClr) tmrCnt <= '0;
    else if (tick && !tmrDone)  tmrCnt <= tmrCnt + 1'b1;
  end

  logic [OW-1:0] ovpCnt;
  assign ovpQual = (ovpCnt >= OW'(OVP_TICKS));

  always_ff @(posedge clk) begin
    if (!rstN || !ovpS)         ovpCnt <= '0;
    else if (tick && !ovpQual)  ovpCnt <= ovpCnt + 1'b1;
  end
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hvOkS,
  input  logic       aboveInhS,
  input  logic       aboveOnS,
  input  logic       belowOffS,
  input  logic       belowRstS,
  input  logic       faultS,
  input  logic       tmrDone,
  input  logic       ovpQual,
  output seqStrobe_t strobe,
  output logic       lowSrcEn,
  output logic       highSrcEn,
  output logic       switchGo,
  output logic       ovpLatched
);
  seqState_t state, nextState;
  logic fromRun, fromRunNext;

  always_comb begin
    nextState   = state;
    fromRunNext = fromRun;
    unique case (state)
      ST_CHARGE:    if (aboveOnS) nextState = ST_STARTWAIT;
      ST_STARTWAIT: if (tmrDone) nextState = faultS ? ST_HOLD : ST_RUN;
      ST_RUN: begin
        if (faultS) nextState = ST_HOLD;
        else if (belowOffS) begin
          nextState   = ST_OFFWAIT;
          fromRunNext = 1'b1;
        end
      end
      ST_HOLD: begin
        if (belowOffS) begin
          nextState   = ST_OFFWAIT;
          fromRunNext = 1'b0;
        end else if (!faultS) nextState = ST_CHARGE;
      end
      ST_OFFWAIT: begin
        if (faultS) fromRunNext = 1'b0;
        if (tmrDone) nextState = ST_CHARGE;
        else if (!belowOffS)
          nextState = (fromRun && !faultS) ? ST_RUN : ST_HOLD;
      end
      ST_OVPLATCH:  if (belowRstS) nextState = ST_CHARGE;
      default:      nextState = ST_CHARGE;
    endcase
    if (ovpQual && state != ST_OVPLATCH) nextState = ST_OVPLATCH;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_CHARGE;
      fromRun <= 1'b0;
    end else begin
      state   <= nextState;
      fromRun <= fromRunNext;
    end
  end

  assign strobe.tmrClr = (nextState != state);
  assign strobe.selOff = (state == ST_OFFWAIT);

  assign lowSrcEn   = (state == ST_CHARGE) && hvOkS && !aboveInhS;
  assign highSrcEn  = (state == ST_CHARGE) && hvOkS && aboveInhS;
  assign switchGo   = (state == ST_RUN) || (state == ST_OFFWAIT && fromRun);
  assign ovpLatched = (state == ST_OVPLATCH);
endmodule

// File: rtl/supply_seq.sv
module supply_seq
  import ssq_pkg::*;
#(
  parameter int PRESCALE    = 100,
  parameter int START_TICKS = 34,
  parameter int OFF_TICKS   = 42,
  parameter int OVP_TICKS   = 63
) (
  input  logic clk,
  input  logic rstN,
  input  logic hvOk,
  input  logic railAboveInh,
  input  logic railAboveOn,
  input  logic railBelowOff,
  input  logic railBelowRst,
  input  logic railOvp,
  input  logic faultIn,
  output logic lowSrcEn,
  output logic highSrcEn,
  output logic switchGo,
  output logic ovpLatched
);
  localparam int NFLAG = 7;

  logic [NFLAG-1:0] rawFlags, syncFlags;
  seqStrobe_t strobe;
  logic tmrDone, ovpQual;

  assign rawFlags = {faultIn, railOvp, railBelowRst, railBelowOff,
                     railAboveOn, railAboveInh, hvOk};

  ssq_sync #(.W(NFLAG)) u_sync (
    .clk(clk), .rstN(rstN), .din(rawFlags), .dout(syncFlags)
  );

  ssq_timebase #(
    .PRESCALE(PRESCALE), .START_TICKS(START_TICKS),
    .OFF_TICKS(OFF_TICKS), .OVP_TICKS(OVP_TICKS)
  ) u_tb (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ovpS(syncFlags[5]),
    .tmrDone(tmrDone), .ovpQual(ovpQual)
  );

  ssq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .hvOkS(syncFlags[0]), .aboveInhS(syncFlags[1]), .aboveOnS(syncFlags[2]),
    .belowOffS(syncFlags[3]), .belowRstS(syncFlags[4]), .faultS(syncFlags[6]),
    .tmrDone(tmrDone), .ovpQual(ovpQual), .strobe(strobe),
    .lowSrcEn(lowSrcEn), .highSrcEn(highSrcEn),
    .switchGo(switchGo), .ovpLatched(ovpLatched)
  );
endmodule

// File: rtl/ssq_chk.sv
module ssq_chk (
  input logic clk,
  input logic rstN,
  input logic railBelowRst,
  input logic lowSrcEn,
  input logic highSrcEn,
  input logic switchGo,
  input logic ovpLatched
);
  // R1: reset clears all outputs
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!lowSrcEn && !highSrcEn && !switchGo && !ovpLatched));

  // R2: the two sources are never enabled together
  p_src_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(lowSrcEn && highSrcEn));

  // R4: no charging while switching is permitted
  p_no_charge_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    switchGo |-> (!lowSrcEn && !highSrcEn));

  // R8: the latched state is fully quiet
  p_ovp_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovpLatched |-> (!lowSrcEn && !highSrcEn && !switchGo));

  // R9: latch persists unless the reset threshold was seen
  p_ovp_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovpLatched && !railBelowRst && !$past(railBelowRst)) |=> ovpLatched);
endmodule

bind supply_seq ssq_chk u_chk (
  .clk(clk), .rstN(rstN), .railBelowRst(railBelowRst),
  .lowSrcEn(lowSrcEn), .highSrcEn(highSrcEn),
  .switchGo(switchGo), .ovpLatched(ovpLatched)
);

// File: tb/sim_supply_seq.sv
`timescale 1ns/1ps
module sim_supply_seq;
  localparam int P  = 2;
  localparam int ST = 5;
  localparam int OF = 4;
  localparam int OV = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hvOk = 0, railAboveInh = 0, railAboveOn = 0, railBelowOff = 1;
  logic railBelowRst = 1, railOvp = 0, faultIn = 0;
  logic lowSrcEn, highSrcEn, switchGo, ovpLatched;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  supply_seq #(.PRESCALE(P), .START_TICKS(ST), .OFF_TICKS(OF), .OVP_TICKS(OV)) u0 (
    .clk(clk), .rstN(rstN), .hvOk(hvOk), .railAboveInh(railAboveInh),
    .railAboveOn(railAboveOn), .railBelowOff(railBelowOff),
    .railBelowRst(railBelowRst), .railOvp(railOvp), .faultIn(faultIn),
    .lowSrcEn(lowSrcEn), .highSrcEn(highSrcEn),
    .switchGo(switchGo), .ovpLatched(ovpLatched)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // outputs packed as {low, high, go, ovp}
  task automatic chkAll(input string req, input logic [3:0] exp);
    chk(req, "lowSrcEn",   lowSrcEn,   exp[3]);
    chk(req, "highSrcEn",  highSrcEn,  exp[2]);
    chk(req, "switchGo",   switchGo,   exp[1]);
    chk(req, "ovpLatched", ovpLatched, exp[0]);
  endtask

  initial begin
    step(3);
    chkAll("R1", 4'b0000);
    rstN = 1'b1;
    step(4);
    chkAll("R2", 4'b0000);                 // no hv, no source
    hvOk = 1; step(4);
    chkAll("R2", 4'b1000);                 // weak source
    railAboveInh = 1; railBelowRst = 0; step(4);
    chkAll("R3", 4'b0100);                 // strong source
    railAboveInh = 0; step(4);
    chkAll("R3", 4'b1000);                 // reverts to weak
    railAboveInh = 1; railBelowOff = 0; step(4);
    railAboveOn = 1; step(4);
    chkAll("R4", 4'b0000);                 // sources off at turn-on
    step(4);                               // 8 cycles after turn-on
    chk("R5", "switchGo early", switchGo, 1'b0);
    step(8);                               // 16 cycles
    chkAll("R5", 4'b0010);
    // undervoltage: drive continues through timeout, then recharge
    railAboveOn = 0; railAboveInh = 0; railBelowOff = 1; step(4);
    chkAll("R7", 4'b0010);
    step(12);
    chkAll("R7", 4'b1000);
    railAboveInh = 1; railBelowOff = 0; railAboveOn = 1; step(20);
    chk("R7", "switchGo after recovery", switchGo, 1'b1);
    // brief dip cancelled before timeout
    railBelowOff = 1; step(4);
    railBelowOff = 0; step(20);
    chkAll("R7", 4'b0010);
    // fault during switching
    faultIn = 1; step(4);
    chkAll("R10", 4'b0000);
    // hiccup: rail sags and is recharged while fault persists
    railBelowOff = 1; railAboveOn = 0; railAboveInh = 0; step(16);
    chkAll("R6", 4'b1000);
    railAboveInh = 1; railBelowOff = 0; railAboveOn = 1; step(20);
    chkAll("R6", 4'b0000);
    faultIn = 0; step(24);
    chkAll("R6", 4'b0010);
    // short overvoltage glitch ignored
    railOvp = 1; step(3);
    railOvp = 0; step(8);
    chkAll("R8", 4'b0010);
    // sustained overvoltage latches
    railOvp = 1; step(20);
    chkAll("R8", 4'b0001);
    railOvp = 0; step(10);
    chkAll("R9", 4'b0001);
    railAboveOn = 0; railAboveInh = 0; railBelowOff = 1; step(20);
    chkAll("R9", 4'b0001);
    railBelowRst = 1; step(4);
    chkAll("R9", 4'b1000);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule